// File: doc/BRIEF.md
# Wrapping Down-Counter to 64-bit Tick Extender

This block turns the readings of a free-running 24-bit down-counter into a 64-bit count of elapsed ticks that only ever grows. The counter itself is outside the block: whenever the surrounding logic wants a fresh time value, it presents the raw counter reading and pulses a sample strobe. The block works out how far the counter has moved since the previous sample, adds that distance to a wide accumulator and keeps the new reading as the reference for the next sample.

The elapsed distance is taken modulo 2^24. A reading that is equal to or below the reference means the counter simply moved down. A reading above the reference means it passed through zero and reloaded from its maximum once. The block does not detect more than one wrap between two samples, so the caller must sample at least once per counter period. The reading bus can be wider than the counter, and the bits above the counter width are dropped.

Top module: `tick_extender`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count output is 0 and the valid output is 0. The reference reading starts at 0xFFFFFF, so a first sample of value v adds 0xFFFFFF − v.
- R2: Only bits [23:0] of the reading input are used. Bits above bit 23 have no effect on the count.
- R3: When the new reading is less than or equal to the reference, the count grows by (reference − reading).
- R4: When the new reading is greater than the reference, the count grows by reference + 2^24 − reading. For example, a reference of 0 and a reading of 0xFFFFFF adds 1.
- R5: After every sample, the reference becomes the masked reading of that sample.
- R6: The updated count appears on the clock edge after the strobe's cycle. Valid is high for exactly that one cycle per strobe, and strobes on consecutive cycles are each accounted for.
- R7: A sample equal to the reference adds zero and leaves the count unchanged.
- R8: In a cycle without a strobe, the count and the reference hold, and valid is 0 in the following cycle.
- R9: The accumulator wraps modulo 2^ACC_W (64 by default) and does not saturate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | Take the current reading this cycle |
| raw_cnt_i | input | RAW_W (32) | Down-counter reading; only the low CNT_W (24) bits are used |
| ticks_o | output | ACC_W (64) | Accumulated elapsed ticks |
| ticks_vld_o | output | 1 | One-cycle pulse marking an updated count |

## Verification
The in-RTL properties check several rules on every cycle: valid follows the strobe by one cycle, the count and reference hold without a strobe, the reference takes each reading, the accumulator steps by exactly the computed distance, equal readings add nothing, and a wrapped distance is never zero. Only the bench scenarios can show that the distance values are arithmetically right: the wrap through zero at its extreme points, that readings with their upper bits set are counted the same as masked ones, and that the accumulator rolls over. The rollover is shown on a second instance with a narrow accumulator, which a few large steps overflow. The bench's reference model is compared on every clock.

// File: rtl/tick_ext_pkg.sv
package tick_ext_pkg;
    localparam int unsigned TICK_CNT_W_DEF = 24;
    localparam int unsigned TICK_RAW_W_DEF = 32;
    localparam int unsigned TICK_ACC_W_DEF = 64;
endpackage

// File: rtl/tick_delta.sv
module tick_delta #(
    parameter int unsigned CNT_W = tick_ext_pkg::TICK_CNT_W_DEF
) (
    input  logic [CNT_W-1:0] ref_i,
    input  logic [CNT_W-1:0] cur_i,
    output logic [CNT_W-1:0] delta_o,
    output logic             wrapped_o
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] span;

    always_comb begin
        wrapped_o = (cur_i > ref_i);
        if (wrapped_o) begin
            // passed through zero: distance to zero plus distance from reload
            span = {1'b0, ref_i} + ({1'b1, {CNT_W{1'b0}}} - {1'b0, cur_i});
        end else begin
            span = {1'b0, ref_i} - {1'b0, cur_i};
        end
        delta_o = span[CNT_W-1:0];
    end

    always_comb begin
        if (wrapped_o) begin
            a_wrap_nonzero_r4: assert (delta_o != '0 || $isunknown(cur_i))
                else $error("wrapped distance is zero");
        end
    end
endmodule

// File: rtl/tick_accum.sv
module tick_accum #(
    parameter int unsigned ACC_W = tick_ext_pkg::TICK_ACC_W_DEF,
    parameter int unsigned CNT_W = tick_ext_pkg::TICK_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en_i,
    input  logic [CNT_W-1:0] delta_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int unsigned PAD_W = ACC_W - CNT_W;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] delta_ext;

    assign delta_ext = {{PAD_W{1'b0}}, delta_i};

    always_comb begin
        acc_d = acc_q;
        if (add_en_i) begin
            acc_d = acc_q + delta_ext;   // modulo 2^ACC_W, no clamp
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        add_en_i |=> acc_q == $past(acc_q) + $past(delta_ext))
        else $error("accumulator step mismatch");

    p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en_i |=> $stable(acc_q))
        else $error("accumulator moved without strobe");
endmodule

// File: rtl/tick_extender.sv
module tick_extender #(
    parameter int unsigned CNT_W = tick_ext_pkg::TICK_CNT_W_DEF,
    parameter int unsigned RAW_W = tick_ext_pkg::TICK_RAW_W_DEF,
    parameter int unsigned ACC_W = tick_ext_pkg::TICK_ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb_i,
    input  logic [RAW_W-1:0] raw_cnt_i,
    output logic [ACC_W-1:0] ticks_o,
    output logic             ticks_vld_o
);
    localparam logic [CNT_W-1:0] RELOAD_VAL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] ref_rd;
        logic             vld;
    } ext_state_t;

    ext_state_t st_d, st_q;

    logic [CNT_W-1:0] cur_rd;
    logic [CNT_W-1:0] step;
    logic             wrapped;

    generate
        if (RAW_W > CNT_W) begin : g_drop_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^raw_cnt_i[RAW_W-1:CNT_W];
        end
    endgenerate
    assign cur_rd = raw_cnt_i[CNT_W-1:0];

    tick_delta #(.CNT_W(CNT_W)) u_delta (
        .ref_i     (st_q.ref_rd),
        .cur_i     (cur_rd),
        .delta_o   (step),
        .wrapped_o (wrapped)
    );

    tick_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en_i (smp_stb_i),
        .delta_i  (step),
        .acc_o    (ticks_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_stb_i;
        if (smp_stb_i) begin
            st_d.ref_rd = cur_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ref_rd <= RELOAD_VAL;
            st_q.vld    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ticks_vld_o = st_q.vld;

    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_i |=> ticks_vld_o)
        else $error("valid missing after strobe");

    p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb_i |=> !ticks_vld_o)
        else $error("valid without strobe");

    p_ticks_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb_i |=> $stable(ticks_o) && $stable(st_q.ref_rd))
        else $error("state moved without strobe");

    p_ref_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_i |=> st_q.ref_rd == $past(cur_rd))
        else $error("reference not updated");

    p_same_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb_i && cur_rd == st_q.ref_rd) |=> $stable(ticks_o))
        else $error("equal reading changed count");
endmodule

// File: tb/tick_extender_tb.sv
module tick_extender_tb;
    localparam int unsigned CW = 24;
    localparam int unsigned RW = 32;
    localparam int unsigned NARROW_W = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic [RW-1:0] raw = '0;
    logic [63:0] ticks;
    logic [NARROW_W-1:0] ticks_n;
    logic vld, vld_n;

    always #4 clk = ~clk;

    tick_extender #(.CNT_W(CW), .RAW_W(RW), .ACC_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb_i(stb), .raw_cnt_i(raw),
        .ticks_o(ticks), .ticks_vld_o(vld));

    tick_extender #(.CNT_W(CW), .RAW_W(RW), .ACC_W(NARROW_W)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .smp_stb_i(stb), .raw_cnt_i(raw),
        .ticks_o(ticks_n), .ticks_vld_o(vld_n));

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit running = 1'b1;
    bit narrow_wrapped = 1'b0;

    logic [63:0] m_acc;
    logic [23:0] m_ref;
    bit          m_vld;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // behavioural model, compared on every clock
    always begin
        @(posedge clk);
        if (running) begin
            if (!rst_n) begin
                m_acc = 64'd0;
                m_ref = 24'hFFFFFF;
                m_vld = 1'b0;
            end else if (stb) begin
                longint unsigned c, r, d;
                c = longint'(raw) & 64'hFFFFFF;
                r = longint'(m_ref);
                if (c <= r) d = r - c;
                else        d = r + 64'd16777216 - c;
                if (((m_acc + d) & ((64'd1 << NARROW_W) - 1)) < (m_acc & ((64'd1 << NARROW_W) - 1)))
                    narrow_wrapped = 1'b1;
                m_acc = m_acc + d;
                m_ref = c[23:0];
                m_vld = 1'b1;
            end else begin
                m_vld = 1'b0;
            end
            #2;
            chk(tag, "count", ticks, m_acc);
            chk(tag, "valid", {63'd0, vld}, {63'd0, m_vld});
            chk(tag, "narrow count", {38'd0, ticks_n}, m_acc & ((64'd1 << NARROW_W) - 1));
            chk(tag, "narrow valid", {63'd0, vld_n}, {63'd0, m_vld});
        end
    end

    task automatic sample(input logic [RW-1:0] v);
        @(negedge clk);
        stb = 1'b1;
        raw = v;
        @(negedge clk);
        stb = 1'b0;
        raw = $urandom;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        tag = "R2_R7";
        sample(32'hAB_FFFFFF);          // upper bits set, equal to reload: adds 0
        tag = "R3";
        sample(32'h00_FFFF00);          // adds 0xFF
        tag = "R8";
        idle(4);
        tag = "R3";
        sample(32'h00_000010);
        tag = "R4";
        sample(32'h00_00FFF0);          // wrapped
        tag = "R5_R7";
        sample(32'h5A_00FFF0);          // same masked value again: adds 0
        sample(32'h00_00FFF0);
        tag = "R4";
        sample(32'h00_000000);
        sample(32'h00_FFFFFF);          // ref 0 -> 0xFFFFFF adds 1
        tag = "R6";
        @(negedge clk); stb = 1'b1; raw = 32'h00_F00000;
        @(negedge clk); raw = 32'h00_E00000;
        @(negedge clk); raw = 32'hFF_D00000;
        @(negedge clk); stb = 1'b0;
        idle(2);
        tag = "R9";
        for (int k = 0; k < 6; k++) begin
            sample(32'h00_000000);
            sample(32'h00_FFFFFF);
        end
        idle(2);
        n_chk++;
        if (!narrow_wrapped) begin
            n_bad++;
            $display("FAIL R9 narrow rollover: actual 0 expected 1");
        end
        tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        tag = "R1_R3";
        sample(32'h00_FFFFF0);          // first sample after reset adds 0xF
        idle(2);
        running = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule